// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer

This block raises an interrupt after a programmed number of processor clock cycles. A 16-bit down-counter steps once for every cycle in which the per-cycle enable strobe is high and counting is switched on. When the counter is already zero, the next step wraps it to 0xFFFF instead of decrementing. If interrupts are enabled at that moment, the wrap sets a pending flag.

Software programs the timer through a command/data pair that is decoded elsewhere. This block sees only a 4-bit command code, a data byte and a write strobe. Three codes matter here:
- 0xD writes the control byte.
- 0xE writes the counter's low byte.
- 0xF writes the counter's high byte.

Counting and interrupt signalling are switched on by separate bits of the control byte. The counter therefore keeps cycling even while interrupts are off. The interrupt output is a registered copy of the pending flag. An acknowledge input clears the flag.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the counter is 0, counting and interrupts are disabled, nothing is pending and `irq` is 0.
- R2: A write with code 0xD loads the interrupt enable from data bit 0 and the count enable from data bit 7; the other bits are ignored. The new enables act from the following cycle.
- R3: A code 0xD write with data bit 0 clear also clears the pending flag.
- R4: A code 0xE write replaces counter bits 7:0 and a code 0xF write replaces bits 15:8, leaving the other byte untouched. Either write clears the pending flag.
- R5: In a cycle with `cpu_tick` high and counting enabled, a nonzero counter decrements by one, and a zero counter reloads to 0xFFFF.
- R6: The pending flag is set by a 0-to-0xFFFF reload only when interrupts are enabled. The counter keeps cycling while interrupts are disabled.
- R7: While counting is disabled the counter holds its value regardless of `cpu_tick`.
- R8: `irq_ack` high clears the pending flag. A reload with interrupts enabled in the same cycle wins, and the flag stays set.
- R9: `irq` equals the pending flag delayed by one clock. It rises the cycle after the reloading edge.
- R10: A counter-byte write and a counting tick in the same cycle: the write wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Write strobe for the decoded command/data pair |
| cmd_code | input | 4 | Command code (0xD control, 0xE counter low, 0xF counter high) |
| cmd_data | input | 8 | Write data byte |
| cpu_tick | input | 1 | One pulse per counted processor cycle |
| irq_ack | input | 1 | Interrupt acknowledge, clears pending |
| irq | output | 1 | Active-high interrupt request |

## Verification
Only `irq` is visible, so a wrong counter value shows up as an interrupt that arrives a cycle early or late, or not at all. Each scenario therefore loads a count, applies an exact number of ticks, and checks `irq` both one tick short of the reload and one clock after it. This pins the counter to the exact cycle. A pending flag that is set or cleared wrongly appears on `irq` one clock later, so the acknowledge, disable and counter-write cases each sample `irq` two edges after the stimulus.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

    localparam int CODE_W = 4;
    localparam int DATA_W = 8;

    localparam logic [CODE_W-1:0] CMD_CTRL   = 4'hD;
    localparam logic [CODE_W-1:0] CMD_CNT_LO = 4'hE;
    localparam logic [CODE_W-1:0] CMD_CNT_HI = 4'hF;

    localparam int CTRL_IRQ_BIT = 0;
    localparam int CTRL_RUN_BIT = 7;

    typedef struct packed {
        logic run;
        logic irq_en;
    } ctrl_t;

    typedef struct packed {
        logic              wr_ctrl;
        logic              wr_lo;
        logic              wr_hi;
        ctrl_t             ctrl_val;
        logic [DATA_W-1:0] data;
    } cmd_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_timer_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [DATA_W-1:0] cmd_data,
    output cmd_t              dec
);

    always_comb begin
        dec                 = '0;
        dec.wr_ctrl         = cmd_valid && (cmd_code == CMD_CTRL);
        dec.wr_lo           = cmd_valid && (cmd_code == CMD_CNT_LO);
        dec.wr_hi           = cmd_valid && (cmd_code == CMD_CNT_HI);
        dec.ctrl_val.run    = cmd_data[CTRL_RUN_BIT];
        dec.ctrl_val.irq_en = cmd_data[CTRL_IRQ_BIT];
        dec.data            = cmd_data;
    end

endmodule

// File: rtl/irq_down_counter.sv
module irq_down_counter #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              step,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);

    localparam int NUM_LANES = CNT_W / BYTE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    logic [NUM_LANES-1:0] lane_wr;
    logic [CNT_W-1:0]     merged;
    logic                 any_load;
    logic                 at_zero;

    // Each byte lane takes new data when its own write arrives.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        if (i == 0) begin : g_low
            assign lane_wr[i] = load_lo;
        end else if (i == NUM_LANES - 1) begin : g_high
            assign lane_wr[i] = load_hi;
        end else begin : g_mid
            assign lane_wr[i] = 1'b0;
        end
        assign merged[i*BYTE_W +: BYTE_W] =
            lane_wr[i] ? load_data : cnt_q.count[i*BYTE_W +: BYTE_W];
    end

    always_comb begin
        any_load = |lane_wr;
        at_zero  = (cnt_q.count == '0);
        wrap     = step && !any_load && at_zero;
        cnt_d    = cnt_q;
        if (any_load) begin
            cnt_d.count = merged;
        end else if (step) begin
            cnt_d.count = at_zero ? CNT_MAX : cnt_q.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.count;

endmodule

// File: rtl/irq_pend_flag.sv
module irq_pend_flag
    import irq_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_t dec,
    input  logic wrap,
    input  logic irq_ack,
    output logic run,
    output logic irq_en,
    output logic pending,
    output logic irq
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  pend;
        logic  irq;
    } flag_state_t;

    flag_state_t flg_d, flg_q;

    logic disable_wr;
    logic clr_pend;
    logic set_pend;

    always_comb begin
        flg_d      = flg_q;
        disable_wr = dec.wr_ctrl && !dec.ctrl_val.irq_en;
        clr_pend   = irq_ack || dec.wr_lo || dec.wr_hi || disable_wr;
        set_pend   = wrap && flg_q.ctrl.irq_en && !disable_wr;
        if (dec.wr_ctrl) begin
            flg_d.ctrl = dec.ctrl_val;
        end
        flg_d.pend = set_pend || (flg_q.pend && !clr_pend);
        flg_d.irq  = flg_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign run     = flg_q.ctrl.run;
    assign irq_en  = flg_q.ctrl.irq_en;
    assign pending = flg_q.pend;
    assign irq     = flg_q.irq;

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import irq_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cpu_tick,
    input  logic              irq_ack,
    output logic              irq
);

    cmd_t             dec;
    logic             run_q;
    logic             irq_en_q;
    logic             pend_q;
    logic             wrap;
    logic             step;
    logic [CNT_W-1:0] cnt_value;

    assign step = cpu_tick && run_q;

    irq_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_data  (cmd_data),
        .dec       (dec)
    );

    irq_down_counter #(
        .CNT_W  (CNT_W),
        .BYTE_W (DATA_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_lo   (dec.wr_lo),
        .load_hi   (dec.wr_hi),
        .load_data (dec.data),
        .step      (step),
        .count     (cnt_value),
        .wrap      (wrap)
    );

    irq_pend_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .wrap    (wrap),
        .irq_ack (irq_ack),
        .run     (run_q),
        .irq_en  (irq_en_q),
        .pending (pend_q),
        .irq     (irq)
    );

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk
    import irq_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [CODE_W-1:0] cmd_code,
    input logic [DATA_W-1:0] cmd_data,
    input logic              cpu_tick,
    input logic              irq_ack,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic              run,
    input logic              irq_en,
    input logic              pend
);

    logic c_ctrl, c_lo, c_hi, c_cnt_wr, c_tick, c_reload;

    always_comb begin
        c_ctrl   = cmd_valid && (cmd_code == CMD_CTRL);
        c_lo     = cmd_valid && (cmd_code == CMD_CNT_LO);
        c_hi     = cmd_valid && (cmd_code == CMD_CNT_HI);
        c_cnt_wr = c_lo || c_hi;
        c_tick   = cpu_tick && run && !c_cnt_wr;
        c_reload = c_tick && (count == '0);
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (irq == 1'b0 && pend == 1'b0 && count == '0 && !run && !irq_en));

    p_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_ctrl |=> (run == $past(cmd_data[CTRL_RUN_BIT]) && irq_en == $past(cmd_data[CTRL_IRQ_BIT])));

    p_disable_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ctrl && !cmd_data[CTRL_IRQ_BIT]) |=> !pend);

    p_lo_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_lo |=> (count[7:0] == $past(cmd_data) && count[CNT_W-1:8] == $past(count[CNT_W-1:8]) && !pend));

    p_hi_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_hi |=> (count[CNT_W-1:8] == $past(cmd_data) && count[7:0] == $past(count[7:0]) && !pend));

    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_tick && count != '0) |=> (count == $past(count) - CNT_W'(1)));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_reload |=> (&count));

    p_set_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(irq_en));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !c_cnt_wr) |=> $stable(count));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(c_reload && irq_en)) |=> !pend);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_reload && irq_en && !(c_ctrl && !cmd_data[CTRL_IRQ_BIT])) |=> pend);

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(pend)));

    p_write_beats_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_lo && cpu_tick && run) |=> (count[CNT_W-1:8] == $past(count[CNT_W-1:8])));

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_data  (cmd_data),
    .cpu_tick  (cpu_tick),
    .irq_ack   (irq_ack),
    .irq       (irq),
    .count     (cnt_value),
    .run       (run_q),
    .irq_en    (irq_en_q),
    .pend      (pend_q)
);

// File: tb/test_cyc_irq_timer.sv
module test_cyc_irq_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'h0;
    logic [7:0] cmd_data = 8'h00;
    logic       cpu_tick = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cyc_irq_timer i_cyc_irq_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_data  (cmd_data),
        .cpu_tick  (cpu_tick),
        .irq_ack   (irq_ack),
        .irq       (irq)
    );

    typedef struct packed {
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [7:0]  ctrl;
        logic [16:0] nt;
        logic        exp;
    } vec_t;

    // load lo/hi, write ctrl, apply nt ticks, one idle clock, expect irq
    localparam vec_t VECS [8] = '{
        '{8'h03, 8'h00, 8'h81, 17'd4,   1'b1},
        '{8'h03, 8'h00, 8'h81, 17'd3,   1'b0},
        '{8'h00, 8'h00, 8'h81, 17'd1,   1'b1},
        '{8'h05, 8'h00, 8'h80, 17'd6,   1'b0},
        '{8'h05, 8'h00, 8'h01, 17'd10,  1'b0},
        '{8'h02, 8'h01, 8'h81, 17'd259, 1'b1},
        '{8'h02, 8'h01, 8'h81, 17'd258, 1'b0},
        '{8'h02, 8'h00, 8'hFF, 17'd3,   1'b1}
    };

    task automatic step(input logic v, input logic [3:0] c, input logic [7:0] d,
                        input logic t, input logic a);
        cmd_valid = v;
        cmd_code  = c;
        cmd_data  = d;
        cpu_tick  = t;
        irq_ack   = a;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        cpu_tick  = 1'b0;
        irq_ack   = 1'b0;
    endtask

    task automatic wr(input logic [3:0] c, input logic [7:0] d);
        step(1'b1, c, d, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, 4'h0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic chk(input logic exp, input string tag);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s: irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(1'b0, "R1 irq low in reset");
        rst_n = 1'b1;
        idle();
        chk(1'b0, "R1 irq low after reset");
        // counter must be 0 after reset: a single tick reloads it
        wr(4'hD, 8'h81);
        ticks(1);
        idle();
        chk(1'b1, "R1 counter zero after reset");
        step(1'b0, 4'h0, 8'h00, 1'b0, 1'b1);
        idle();

        // table walk: R2 R4 R5 R6 R7
        foreach (VECS[i]) begin
            step(1'b0, 4'h0, 8'h00, 1'b0, 1'b1);
            wr(4'hD, 8'h00);
            wr(4'hE, VECS[i].lo);
            wr(4'hF, VECS[i].hi);
            wr(4'hD, VECS[i].ctrl);
            ticks(int'(VECS[i].nt));
            idle();
            chk(VECS[i].exp, $sformatf("R2 R4 R5 R6 R7 vector %0d", i));
        end

        // R9: irq rises one clock after the reloading edge
        step(1'b0, 4'h0, 8'h00, 1'b0, 1'b1);
        wr(4'hD, 8'h00);
        wr(4'hE, 8'h01);
        wr(4'hF, 8'h00);
        wr(4'hD, 8'h81);
        ticks(2);
        chk(1'b0, "R9 irq not yet high at reload edge");
        idle();
        chk(1'b1, "R9 irq high one clock later");

        // R8: acknowledge clears
        step(1'b0, 4'h0, 8'h00, 1'b0, 1'b1);
        chk(1'b1, "R8 irq still high right after ack edge");
        idle();
        chk(1'b0, "R8 irq cleared by ack");

        // R8: reload with ack in same cycle keeps pending
        wr(4'hE, 8'h00);
        wr(4'hF, 8'h00);
        step(1'b0, 4'h0, 8'h00, 1'b1, 1'b1);
        idle();
        chk(1'b1, "R8 reload beats ack");

        // R3: disabling interrupts clears pending
        wr(4'hD, 8'h80);
        idle();
        chk(1'b0, "R3 irq disable clears pending");

        // R6: counter keeps cycling while irq disabled
        wr(4'hE, 8'h02);
        wr(4'hF, 8'h00);
        ticks(3);
        idle();
        chk(1'b0, "R6 reload without irq enable sets nothing");
        wr(4'hF, 8'h00);
        wr(4'hD, 8'h81);
        ticks(255);
        idle();
        chk(1'b0, "R6 R4 counter at 0x00FF reaches zero without irq");
        ticks(1);
        idle();
        chk(1'b1, "R6 R4 reload after free-run wrap");

        // R4: counter write clears pending
        wr(4'hE, 8'h05);
        idle();
        chk(1'b0, "R4 counter write clears pending");

        // R10: write beats tick
        wr(4'hD, 8'h00);
        wr(4'hE, 8'h05);
        wr(4'hF, 8'h00);
        wr(4'hD, 8'h81);
        ticks(2);
        step(1'b1, 4'hE, 8'h03, 1'b1, 1'b0);
        ticks(3);
        idle();
        chk(1'b0, "R10 write wins, counter at zero not reloaded");
        ticks(1);
        idle();
        chk(1'b1, "R10 reload after written value");

        // R7: hold while counting disabled
        step(1'b0, 4'h0, 8'h00, 1'b0, 1'b1);
        wr(4'hD, 8'h00);
        wr(4'hE, 8'h01);
        wr(4'hF, 8'h00);
        wr(4'hD, 8'h01);
        ticks(5);
        idle();
        chk(1'b0, "R7 no counting while disabled");
        wr(4'hD, 8'h81);
        ticks(1);
        idle();
        chk(1'b0, "R7 value 1 held, first tick reaches zero");
        ticks(1);
        idle();
        chk(1'b1, "R7 second tick reloads");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule